// File: doc/BRIEF.md
# Split-Byte Serial Frame Transmitter

This block is the host-side master for a three-wire serial link to a dual 8-bit converter. It takes a 16-bit command word (a control byte followed by a data byte) through a valid/ready handshake. It then produces an active-low frame-sync, a serial clock that idles low, and serial data. Data is sent most significant bit first and changes only while the serial clock is low, so the receiver can sample it on the rising clock edge.

Two framing modes are available. In burst mode all sixteen clocks run back to back. In split mode the frame is sent as two separately clocked bytes, and frame-sync stays low through the gap between them. An order option reverses the bits inside each byte, for upstream sources that hand over bytes least significant bit first.

Every timing interval is counted in system-clock cycles and set through configuration inputs: the clock half period, the sync setup time, the sync hold time, the inter-byte gap and the sync idle time. All of these, plus the two mode bits, are captured when a command is accepted. A busy output shows that a transfer, or its idle time, is still in progress.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, frame_sync_n is 1, ser_clk is 0, ser_data is 0, cmd_ready is 1 and busy is 0. Whenever frame_sync_n is 1, ser_clk and ser_data are 0.
- R2: Each accepted command produces one frame with exactly 16 rising edges of ser_clk while frame_sync_n is low. The bit sampled at the k-th rising edge is cmd_word[15-k], so bit 15 comes first.
- R3: ser_data changes only in the cycle where ser_clk falls, and stays constant while ser_clk is high. The first bit is present from the cycle in which frame_sync_n falls.
- R4: Every high phase of ser_clk lasts max(cfg_half,1) cycles. Every low phase between two rising edges lasts the same, except at the byte gap of R7.
- R5: The first rising edge of ser_clk comes max(cfg_setup,1) cycles after frame_sync_n falls. frame_sync_n rises max(cfg_hold,1) cycles after the last falling edge of ser_clk.
- R6: Between two frames, frame_sync_n stays high for at least max(cfg_idle,1)+1 cycles. It stays high for exactly that many when the next command is already waiting.
- R7: With split_mode=1, the low phase between the 8th and 9th rising edges lasts max(cfg_half,1)+cfg_gap cycles, and frame_sync_n stays low for the whole frame.
- R8: With lsb_first=1, the bits inside each byte are mirrored, so the bit sent k-th within a byte is word bit (byte base + k).
- R9: Mode and timing inputs are captured on acceptance. Changing them during a frame has no effect on that frame.
- R10: busy is 1 and cmd_ready is 0 from acceptance until the idle time of R6 has elapsed. A cmd_valid pulse during that time is ignored and starts no frame.
- R11: A timing field of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_word | input | WORD_W | Control byte (upper) and data byte (lower) |
| split_mode | input | 1 | 1: two byte bursts with a gap, 0: one 16-clock burst |
| lsb_first | input | 1 | 1: mirror the bit order inside each byte |
| cfg_half | input | CNT_W | Serial clock high and low time in cycles |
| cfg_setup | input | CNT_W | Sync fall to first clock rise, cycles |
| cfg_hold | input | CNT_W | Last clock fall to sync rise, cycles |
| cfg_gap | input | CNT_W | Extra low cycles between the bytes in split mode |
| cfg_idle | input | CNT_W | Minimum sync-high cycles before the next command |
| busy | output | 1 | Transfer or idle time in progress |
| frame_sync_n | output | 1 | Active-low frame-sync |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data |

## Verification
A wrong sequencer state or timer value shows up on the serial pins within the same frame. It appears as a high or low phase of the wrong length, a setup or hold interval that differs from the programmed count, or a frame with fewer or more than sixteen rising edges. A fault in the shift register or the byte mirroring shows up as a decoded word that differs from the expected value in that frame. A fault in the handshake or the idle counter shows up as a wrong sync-high interval between two queued frames, or as an extra frame after a command that should have been ignored. The bench rebuilds every frame from the pin trace and compares each interval with counts computed from the configuration.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_GAP   = 3'd4,
    ST_HOLD  = 3'd5,
    ST_REST  = 3'd6
  } phase_e;
endpackage

// File: rtl/sft_bit_order.sv
module sft_bit_order #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [WORD_W-1:0] in_word,
  input  logic              lsb_first,
  output logic [WORD_W-1:0] out_word
);
  localparam int N_BYTES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] mirrored;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign mirrored[b*BYTE_W + i] = in_word[b*BYTE_W + BYTE_W - 1 - i];
    end
  end

  assign out_word = lsb_first ? mirrored : in_word;
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              msb
);
  logic [WORD_W-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
    end else if (load) begin
      shreg_q <= load_word;
    end else if (shift) begin
      shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
    end
  end

  assign msb = shreg_q[WORD_W-1];
endmodule

// File: rtl/sft_timer.sv
module sft_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sft_sequencer.sv
module sft_sequencer
  import sft_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  output logic             busy,
  input  logic             split_mode,
  input  logic [CNT_W-1:0] cfg_half,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_hold,
  input  logic [CNT_W-1:0] cfg_gap,
  input  logic [CNT_W-1:0] cfg_idle,
  input  logic             timer_done,
  output logic             timer_load,
  output logic [CNT_W:0]   timer_val,
  output logic             load_en,
  output logic             shift_en,
  output phase_e           state
);
  localparam int TW       = CNT_W + 1;
  localparam int BIT_W    = $clog2(WORD_W);
  localparam int BYTE_IDX = $clog2(BYTE_W);

  phase_e            state_q, state_d;
  logic [BIT_W-1:0]  bit_q;
  logic              split_q;
  logic [CNT_W-1:0]  half_q, hold_q, gap_q, idle_q;
  logic              accept, last_bit, byte_end;

  function automatic logic [TW-1:0] span(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : (TW'(v) - TW'(1));
  endfunction

  assign last_bit = (bit_q == BIT_W'(WORD_W - 1));
  assign byte_end = (bit_q[BYTE_IDX-1:0] == BYTE_IDX'(BYTE_W - 1));

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    timer_val  = '0;
    shift_en   = 1'b0;
    accept     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          accept     = 1'b1;
          state_d    = ST_SETUP;
          timer_load = 1'b1;
          timer_val  = span(cfg_setup);
        end
      end
      ST_SETUP: begin
        if (timer_done) begin
          state_d    = ST_HIGH;
          timer_load = 1'b1;
          timer_val  = span(half_q);
        end
      end
      ST_HIGH: begin
        if (timer_done) begin
          shift_en   = 1'b1;
          timer_load = 1'b1;
          if (last_bit) begin
            state_d   = ST_HOLD;
            timer_val = span(hold_q);
          end else if (byte_end && split_q) begin
            state_d   = ST_GAP;
            timer_val = span(half_q) + TW'(gap_q);
          end else begin
            state_d   = ST_LOW;
            timer_val = span(half_q);
          end
        end
      end
      ST_LOW, ST_GAP: begin
        if (timer_done) begin
          state_d    = ST_HIGH;
          timer_load = 1'b1;
          timer_val  = span(half_q);
        end
      end
      ST_HOLD: begin
        if (timer_done) begin
          state_d    = ST_REST;
          timer_load = 1'b1;
          timer_val  = span(idle_q);
        end
      end
      ST_REST: begin
        if (timer_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      split_q <= 1'b0;
      half_q  <= '0;
      hold_q  <= '0;
      gap_q   <= '0;
      idle_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        bit_q   <= '0;
        split_q <= split_mode;
        half_q  <= cfg_half;
        hold_q  <= cfg_hold;
        gap_q   <= cfg_gap;
        idle_q  <= cfg_idle;
      end else if (shift_en) begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign load_en   = accept;
  assign state     = state_q;

  // R10: an accepted command always starts the setup interval
  p_accept_starts_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (state_q == ST_SETUP));

  // R7: the byte gap only occurs in a frame captured in split mode
  p_gap_split_only_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP) |-> split_q);

  // R2: hold is entered only after all bits are sent (counter wrapped)
  p_hold_all_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) |-> (bit_q == '0));

  // R9: captured timing is stable during a frame
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(cmd_ready)) |-> ($stable(half_q) && $stable(split_q)));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              split_mode,
  input  logic              lsb_first,
  input  logic [CNT_W-1:0]  cfg_half,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [CNT_W-1:0]  cfg_gap,
  input  logic [CNT_W-1:0]  cfg_idle,
  output logic              busy,
  output logic              frame_sync_n,
  output logic              ser_clk,
  output logic              ser_data
);
  localparam int TW = CNT_W + 1;

  logic [WORD_W-1:0] ordered;
  logic              timer_done, timer_load, load_en, shift_en, msb;
  logic [TW-1:0]     timer_val;
  phase_e            state;
  logic              active;

  sft_bit_order #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_order (
    .in_word  (cmd_word),
    .lsb_first(lsb_first),
    .out_word (ordered)
  );

  sft_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (timer_load),
    .load_val(timer_val),
    .done    (timer_done)
  );

  sft_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load_en),
    .load_word(ordered),
    .shift    (shift_en),
    .msb      (msb)
  );

  sft_sequencer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .split_mode(split_mode),
    .cfg_half  (cfg_half),
    .cfg_setup (cfg_setup),
    .cfg_hold  (cfg_hold),
    .cfg_gap   (cfg_gap),
    .cfg_idle  (cfg_idle),
    .timer_done(timer_done),
    .timer_load(timer_load),
    .timer_val (timer_val),
    .load_en   (load_en),
    .shift_en  (shift_en),
    .state     (state)
  );

  assign active = (state == ST_SETUP) || (state == ST_HIGH) || (state == ST_LOW) ||
                  (state == ST_GAP)   || (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_sync_n <= 1'b1;
      ser_clk      <= 1'b0;
      ser_data     <= 1'b0;
    end else begin
      frame_sync_n <= ~active;
      ser_clk      <= (state == ST_HIGH);
      ser_data     <= active & msb;
    end
  end

  // R1: clock idles low outside a frame
  p_clk_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    frame_sync_n |-> !ser_clk);

  // R1: data line quiet outside a frame
  p_data_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    frame_sync_n |-> !ser_data);

  // R3: data never moves while the serial clock is high
  p_data_stable_high_r3: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> $stable(ser_data));

  // R10: no new frame starts while the line is held off by the idle time
  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_sync_n) |-> busy);
endmodule

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;
  localparam int W = 16;
  localparam int CW = 8;
  localparam int TMAX = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [W-1:0] cmd_word = '0;
  logic split_mode = 1'b0, lsb_first = 1'b0;
  logic [CW-1:0] cfg_half = 8'd2, cfg_setup = 8'd1, cfg_hold = 8'd1, cfg_gap = 8'd0, cfg_idle = 8'd4;
  logic cmd_ready, busy, frame_sync_n, ser_clk, ser_data;

  serial_frame_tx #(.WORD_W(W), .BYTE_W(8), .CNT_W(CW)) i_serial_frame_tx (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .split_mode(split_mode), .lsb_first(lsb_first), .cfg_half(cfg_half), .cfg_setup(cfg_setup),
    .cfg_hold(cfg_hold), .cfg_gap(cfg_gap), .cfg_idle(cfg_idle), .busy(busy),
    .frame_sync_n(frame_sync_n), .ser_clk(ser_clk), .ser_data(ser_data)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic sync_t [0:TMAX-1];
  logic sclk_t [0:TMAX-1];
  logic sdo_t  [0:TMAX-1];
  int tlen = 0;
  bit rec = 1'b0;

  always @(negedge clk) if (rec && tlen < TMAX) begin
    sync_t[tlen] = frame_sync_n;
    sclk_t[tlen] = ser_clk;
    sdo_t[tlen]  = ser_data;
    tlen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [15:0] order(input logic [15:0] w, input bit lsb);
    logic [15:0] r;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++)
        r[b*8+i] = lsb ? w[b*8+7-i] : w[b*8+i];
    return r;
  endfunction

  // Rebuild one frame from the trace starting at index start.
  task automatic decode(input int start, input logic [15:0] expw, input bit split,
                        input int half, input int setup, input int hold, input int gap,
                        output int endidx);
    int f, r, rises, first_rise, last_rise, last_fall, hi_bad, lo_bad, data_bad;
    logic [15:0] got;
    f = start;
    while (f < tlen && sync_t[f]) f++;
    if (f >= tlen) begin
      chk(1'b0, "R2 frame missing", 0, 1);
      endidx = tlen;
      return;
    end
    r = f;
    while (r < tlen && !sync_t[r]) r++;
    rises = 0; first_rise = -1; last_rise = f; last_fall = f;
    hi_bad = 0; lo_bad = 0; data_bad = 0; got = '0;
    for (int i = f + 1; i < r; i++) begin
      if (sclk_t[i] && !sclk_t[i-1]) begin
        if (first_rise < 0) first_rise = i;
        else if (i - last_fall != ((split && rises == 8) ? eff(half) + gap : eff(half))) lo_bad++;
        got = {got[14:0], sdo_t[i]};
        rises++;
        last_rise = i;
      end
      if (!sclk_t[i] && sclk_t[i-1]) begin
        if (i - last_rise != eff(half)) hi_bad++;
        last_fall = i;
      end
      if (sdo_t[i] != sdo_t[i-1] && !(!sclk_t[i] && sclk_t[i-1])) data_bad++;
    end
    chk(rises == 16, "R2 rising edge count", rises, 16);
    chk(got == expw, "R2/R8 decoded word", int'(got), int'(expw));
    chk(first_rise - f == eff(setup), "R5 sync setup", first_rise - f, eff(setup));
    chk(r - last_fall == eff(hold), "R5 sync hold", r - last_fall, eff(hold));
    chk(hi_bad == 0, "R4 high phase length", hi_bad, 0);
    chk(lo_bad == 0, split ? "R7 gap/low phase length" : "R4 low phase length", lo_bad, 0);
    chk(data_bad == 0, "R3 data changes only at falling clock", data_bad, 0);
    endidx = r;
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_word = w;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e, e2, g, n;
    logic [15:0] w, w2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(frame_sync_n == 1'b1, "R1 sync after reset", frame_sync_n, 1);
    chk(ser_clk == 1'b0, "R1 clock after reset", ser_clk, 0);
    chk(ser_data == 1'b0, "R1 data after reset", ser_data, 0);
    chk(cmd_ready == 1'b1 && busy == 1'b0, "R1 ready/busy after reset", {cmd_ready, busy}, 2);

    // Sweep over half period, framing mode and bit order (R2 R3 R4 R5 R7 R8 R9 R11)
    n = 0;
    for (int h = 1; h <= 3; h++) begin
      for (int sp = 0; sp < 2; sp++) begin
        for (int lb = 0; lb < 2; lb++) begin
          int su, ho, ga;
          su = (h + sp + lb) % 3;      // includes 0 to cover R11
          ho = (lb == 0) ? 1 : 0;      // includes 0 to cover R11
          ga = (h % 2) * 2 + sp;
          w = 16'h8001 ^ 16'(n * 16'h1D35) ^ 16'(h << 9);
          cfg_half = CW'(h); cfg_setup = CW'(su); cfg_hold = CW'(ho);
          cfg_gap = CW'(ga); cfg_idle = CW'(h);
          split_mode = sp[0]; lsb_first = lb[0];
          tlen = 0; rec = 1'b1;
          send(w);
          // R10: busy during the frame
          chk(busy == 1'b1 && cmd_ready == 1'b0, "R10 busy during frame", {busy, cmd_ready}, 2);
          // R9: disturb the inputs mid-frame
          cfg_half = 8'd7; cfg_setup = 8'd9; cfg_hold = 8'd5; cfg_gap = 8'd6;
          split_mode = ~split_mode; lsb_first = ~lsb_first;
          wait_ready();
          rec = 1'b0;
          decode(0, order(w, lb[0]), sp[0], h, su, ho, ga, e);
          n++;
        end
      end
    end

    // Extremes of the data word (R2)
    for (int k = 0; k < 2; k++) begin
      w = (k == 0) ? 16'hFFFF : 16'h0000;
      cfg_half = 8'd2; cfg_setup = 8'd1; cfg_hold = 8'd1; cfg_gap = 8'd0; cfg_idle = 8'd4;
      split_mode = 1'b0; lsb_first = 1'b0;
      tlen = 0; rec = 1'b1;
      send(w);
      wait_ready();
      rec = 1'b0;
      decode(0, w, 1'b0, 2, 1, 1, 0, e);
    end

    // R6: back-to-back commands, idle gap is exact
    for (int id = 0; id < 3; id++) begin
      w = 16'h3C5A + 16'(id); w2 = 16'hA5C3 - 16'(id);
      cfg_half = 8'd1; cfg_setup = 8'd2; cfg_hold = 8'd2; cfg_gap = 8'd3;
      cfg_idle = CW'(id * 3);
      split_mode = 1'b1; lsb_first = 1'b0;
      tlen = 0; rec = 1'b1;
      @(negedge clk);
      cmd_word = w; cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_word = w2;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_ready();
      rec = 1'b0;
      decode(0, w, 1'b1, 1, 2, 2, 3, e);
      g = e;
      while (g < tlen && sync_t[g]) g++;
      chk(g - e == eff(id * 3) + 1, "R6 sync idle between frames", g - e, eff(id * 3) + 1);
      decode(e, w2, 1'b1, 1, 2, 2, 3, e2);
    end

    // R10: a valid pulse while busy is ignored
    cfg_half = 8'd2; cfg_setup = 8'd1; cfg_hold = 8'd1; cfg_gap = 8'd0; cfg_idle = 8'd2;
    split_mode = 1'b0; lsb_first = 1'b0;
    tlen = 0; rec = 1'b1;
    send(16'h1234);
    repeat (5) @(negedge clk);
    cmd_word = 16'hBEEF; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_ready();
    repeat (40) @(negedge clk);
    rec = 1'b0;
    decode(0, 16'h1234, 1'b0, 2, 1, 1, 0, e);
    g = e;
    while (g < tlen && sync_t[g]) g++;
    chk(g == tlen, "R10 ignored command started no frame", g, tlen);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule